// File: doc/BRIEF.md
# Bridge control register file

This block is a bank of 28 registers, each 32 bits wide, sitting behind a plain single-cycle read/write port with a byte offset. It holds the configuration, GPIO, interrupt-controller, mailbox and timing words of a host bridge. Reads are combinational from the offset. Writes take effect at the clock edge.

Most words store whatever is written to them. The interrupt-enable word is different: it changes only through two alias words. One ORs written bits into it and the other clears them. Two words ignore direct writes. When software sets bit 2 of the general-configuration word from 0 to 1, the block raises a one-cycle system reset request. A write beyond the bank is dropped and sets a sticky error flag.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset, these offsets hold fixed values: 0x00 = 0x00000C40, 0x04 = 0x00001384, 0x08 = 0x2BFF8010, 0x0C = 0x255E0091, 0x10 = 0x00006140, 0x1C = 0x000001FF, 0x20 = 0x000001FF, 0x68 = 0x00000008, 0x6C = 0x10000000. Every other word reads 0, and `wr_err` and `sys_reset_req` are 0.
- R2: The word index is the byte offset shifted right by 2, so the two low offset bits are ignored on reads and writes. A read of any offset from 0x00 to 0x6F returns the stored word in the same cycle.
- R3: A write to any offset other than 0x30, 0x34, 0x38 or 0x3C stores the full 32-bit data word. Writes to 0x30 and 0x34 also store the data word.
- R4: A write to 0x30 ORs the data into the interrupt-enable word at 0x38.
- R5: A write to 0x34 clears, in the enable word at 0x38, every bit that is set in the data.
- R6: Direct writes to 0x38 (enable) and 0x3C (status) change nothing. The status word reads 0.
- R7: A write to 0x04 whose stored bit 2 is 0 and whose data bit 2 is 1 drives `sys_reset_req` high for exactly the one cycle after the write edge.
- R8: A write to 0x04 raises no request when the stored bit 2 is already 1 or the data bit 2 is 0. A request does not alter any stored word.
- R9: A write to an offset of 0x70 or above changes no word and sets `wr_err`. Reads of such offsets return 0.
- R10: `wr_err` stays set until reset and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset for the read and the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_reset_req | output | 1 | One-cycle system reset request |
| wr_err | output | 1 | Sticky out-of-bank write flag |

## Verification
The hardest case to reach is the reset request. The general-configuration word comes out of reset with bit 2 already set, so a plain write of a value with bit 2 set produces no pulse. The stimulus therefore first writes that word with bit 2 cleared, then sets it. It then repeats the write with the bit still set to show that no second pulse appears. The enable word is driven through interleaved set and clear patterns, each with a direct write to it in between. A bench-side model of the bank is compared against every readable word after each write.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int DATA_W      = 32;
  localparam int IDX_GENCFG  = 1;
  localparam int IDX_EN_SET  = 12;
  localparam int IDX_EN_CLR  = 13;
  localparam int IDX_EN      = 14;
  localparam int IDX_ISR     = 15;
  localparam int GEN_RST_BIT = 2;

  // Power-on contents of each word.
  function automatic logic [DATA_W-1:0] reset_word(input int idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction

  // Words that a direct write may not touch.
  function automatic logic is_read_only(input int idx);
    return (idx == IDX_EN) || (idx == IDX_ISR);
  endfunction

  // A request fires only on a 0 to 1 change.
  function automatic logic rise_detect(input logic old_b, input logic new_b);
    return !old_b && new_b;
  endfunction

  function automatic logic [DATA_W-1:0] apply_set(input logic [DATA_W-1:0] cur,
                                                  input logic [DATA_W-1:0] bits);
    return cur | bits;
  endfunction

  function automatic logic [DATA_W-1:0] apply_clr(input logic [DATA_W-1:0] cur,
                                                  input logic [DATA_W-1:0] bits);
    return cur & ~bits;
  endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 28,
  localparam int WIDX_W   = ADDR_W - 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [WIDX_W-1:0]    word_idx,
  output logic                 in_range,
  output logic [NUM_WORDS-1:0] wr_sel,
  output logic                 wr_oob
);

  assign word_idx = WIDX_W'(bus_addr >> 2);
  assign in_range = (word_idx < WIDX_W'(NUM_WORDS));
  assign wr_oob   = bus_wr && !in_range;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
    assign wr_sel[i] = bus_wr && (word_idx == WIDX_W'(i));
  end

  // R9: a write outside the bank selects no word
  assert_oob_nosel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oob |-> (wr_sel == '0));

endmodule

// File: rtl/ctlreg_inten.sv
module ctlreg_inten
  import ctlreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_stb,
  input  logic              clr_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);

  logic [DATA_W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (set_stb)      en_d = apply_set(en_q, wdata);
    else if (clr_stb) en_d = apply_clr(en_q, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= reset_word(IDX_EN);
    else        en_q <= en_d;
  end

  assert_set_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en_q & $past(wdata)) == $past(wdata)));

  assert_clr_and_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en_q & $past(wdata)) == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(en_q));

endmodule

// File: rtl/ctlreg_rstreq.sv
module ctlreg_rstreq
  import ctlreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gen_wr,
  input  logic old_bit,
  input  logic new_bit,
  output logic req_q
);

  logic fire;
  assign fire = gen_wr && rise_detect(old_bit, new_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= fire;
  end

  assert_pulse_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  assert_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(gen_wr && !old_bit && new_bit));

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_reset_req,
  output logic              wr_err
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]              word_idx;
  logic                           in_range;
  logic [NUM_WORDS-1:0]           wr_sel;
  logic                           wr_oob;
  logic [NUM_WORDS-1:0][DATA_W-1:0] word_q;
  logic [DATA_W-1:0]              en_q;

  ctlreg_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .word_idx (word_idx),
    .in_range (in_range),
    .wr_sel   (wr_sel),
    .wr_oob   (wr_oob)
  );

  ctlreg_inten u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (wr_sel[IDX_EN_SET]),
    .clr_stb (wr_sel[IDX_EN_CLR]),
    .wdata   (bus_wdata),
    .en_q    (en_q)
  );

  ctlreg_rstreq u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .gen_wr  (wr_sel[IDX_GENCFG]),
    .old_bit (word_q[IDX_GENCFG][GEN_RST_BIT]),
    .new_bit (bus_wdata[GEN_RST_BIT]),
    .req_q   (sys_reset_req)
  );

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (i == IDX_EN) begin : g_en
      assign word_q[i] = en_q;
    end else if (is_read_only(i)) begin : g_ro
      assign word_q[i] = reset_word(i);
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= reset_word(i);
        else if (wr_sel[i]) q <= bus_wdata;
      end
      assign word_q[i] = q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (in_range && (word_idx == WIDX_W'(i))) bus_rdata = word_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_err <= 1'b0;
    else if (wr_oob) wr_err <= 1'b1;
  end

  assert_oob_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oob |=> $stable(word_q));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

  assert_direct_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[IDX_EN] |=> $stable(en_q));

endmodule

// File: tb/sim_ctlreg_bank.sv
module sim_ctlreg_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_reset_req;
  logic        wr_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [28];
  logic        model_err;

  always #2 clk = ~clk;

  ctlreg_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_reset_req(sys_reset_req), .wr_err(wr_err)
  );

  function automatic logic [31:0] dflt(input int i);
    case (i)
      0: return 32'hC40;        1: return 32'h1384;
      2: return 32'h2BFF8010;   3: return 32'h255E0091;
      4: return 32'h6140;       7: return 32'h1FF;
      8: return 32'h1FF;        26: return 32'h8;
      27: return 32'h10000000;  default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 28; i++) model[i] = dflt(i);
    model_err = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    #0.5;
    chk(bus_rdata === e, tag, bus_rdata, e);
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 28; i++) rd_chk(8'(i * 4), model[i], tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int idx = int'(a >> 2);
    bit exp_req = (idx == 1) && !model[1][2] && d[2];
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (idx >= 28) model_err = 1'b1;
    else case (idx)
      12: begin model[12] = d; model[14] = model[14] | d; end
      13: begin model[13] = d; model[14] = model[14] & ~d; end
      14, 15: ;
      default: model[idx] = d;
    endcase
    @(posedge clk); #1;
    bus_wr = 1'b0;
    if (idx == 1 && !exp_req)
      chk(sys_reset_req === 1'b0, "R8 no request", 32'(sys_reset_req), 0);
    else
      chk(sys_reset_req === exp_req, "R7 request after write", 32'(sys_reset_req), 32'(exp_req));
    if (exp_req) begin
      @(posedge clk); #1;
      chk(sys_reset_req === 1'b0, "R7 single cycle", 32'(sys_reset_req), 0);
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    check_all("R1 reset value");
    chk(wr_err === 1'b0, "R1 err at reset", 32'(wr_err), 0);
    chk(sys_reset_req === 1'b0, "R1 req at reset", 32'(sys_reset_req), 0);
    // R2 low offset bits ignored on read
    for (int i = 0; i < 28; i++)
      for (int b = 1; b < 4; b++) rd_chk(8'(i * 4 + b), model[i], "R2 low bits read");
    // R3 sweep of every word, with varied low offset bits
    for (int i = 0; i < 28; i++) begin
      logic [31:0] p = {8'(i), ~8'(i), 8'h5A, 8'(i * 17)};
      wr(8'(i * 4 + (i % 4)), p);
      check_all("R3 store sweep");
    end
    // R4 / R5 / R6 enable aliases and read-only words
    for (int k = 0; k < 8; k++) begin
      logic [31:0] s = 32'h0101_0101 << k;
      logic [31:0] c = 32'h1111_0000 >> k;
      wr(8'h30, s ^ 32'(k * 32'h0F0F));
      rd_chk(8'h38, model[14], "R4 enable set");
      wr(8'h38, 32'hFFFF_FFFF);
      rd_chk(8'h38, model[14], "R6 enable direct write");
      wr(8'h34, c | 32'(k));
      rd_chk(8'h38, model[14], "R5 enable clear");
      rd_chk(8'h34, model[13], "R3 clear alias stored");
      wr(8'h3C, 32'hA5A5_5A5A ^ 32'(k));
      rd_chk(8'h3C, 32'h0, "R6 status direct write");
    end
    wr(8'h34, 32'hFFFF_FFFF);
    rd_chk(8'h38, 32'h0, "R5 clear all");
    // R7 / R8 reset request edge
    wr(8'h04, 32'h0000_1380);
    wr(8'h04, 32'h0000_1384);
    check_all("R8 bank kept after request");
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0000_0000);
    wr(8'h05, 32'h0000_0004);
    rd_chk(8'h04, 32'h4, "R2 low bits write");
    // R9 / R10 out of bank
    chk(wr_err === 1'b0, "R9 err before", 32'(wr_err), 0);
    wr(8'h70, 32'hDEAD_BEEF);
    chk(wr_err === 1'b1, "R9 err set", 32'(wr_err), 1);
    check_all("R9 bank unchanged");
    for (int a = 8'h70; a < 256; a += 4) rd_chk(8'(a), 32'h0, "R9 read outside");
    wr(8'hFC, 32'h1234_5678);
    wr(8'h20, 32'h0000_00AA);
    chk(wr_err === 1'b1, "R10 err sticky", 32'(wr_err), 1);
    check_all("R10 bank after");
    // R1 / R10 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    #0.5;
    chk(wr_err === 1'b0, "R10 err cleared by reset", 32'(wr_err), 0);
    check_all("R1 defaults after reset");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule